// File: doc/BRIEF.md
# Fault Injection Glitch Timing Controller

This block turns a stream of command bytes into supply-voltage glitch attempts against a target board. Each byte arrives over a valid/data handshake from a serial receiver. The commands set a post-reset delay and a glitch width, both counted in system clock cycles. Other commands start a single attempt, pulse the target reset on its own, start a sweep, or abort whatever is running.

An attempt runs through four stages in order:
- The target reset is held low for a fixed number of cycles.
- The reset is released and the configured delay is counted.
- A trigger hands over to the pulse stage.
- The power-multiplexer select output is driven high for exactly the configured width.

Every timing point is fixed relative to the first cycle of reset release, so there is no jitter from one attempt to the next. When an attempt ends, a one-cycle done strobe reports the delay and width that were used. In sweep mode the width advances in the inner loop and the delay in the outer loop, so a host can search the delay/width space while logging each combination.

Top module: `glitch_timing_ctrl`

## Requirements
- R1: Command framing. Opcodes 0x01 (set delay), 0x02 (set width) and 0x05 (sweep) are each followed by a 16-bit argument sent low byte first. Opcodes 0x03 (single run), 0x04 (target reset only) and 0x06 (stop) take no argument. Any other opcode byte is dropped and does not disturb the framing of the bytes that follow.
- R2: An attempt drives the active-low target reset output low for exactly RST_HOLD consecutive cycles (default 1024).
- R3: With delay D, the glitch output first goes high D+1 cycles after the first cycle in which the target reset is high again. A delay of 0 therefore fires on the cycle after release.
- R4: With width W, the glitch output stays high for exactly W consecutive cycles. A width of 0 produces no pulse at all.
- R5: A one-cycle done strobe comes in the cycle after the last pulse cycle, or D+1 cycles after release when W is 0. In that cycle the delay and width outputs carry the D and W that the attempt used.
- R6: Busy is high in every cycle of reset hold and pulse. For a single run, busy is low in the done cycle.
- R7: A command whose final byte is accepted while busy is high has no effect, with the exception of stop. This covers settings as well as starts.
- R8: Stop aborts at once. On the second clock edge after the stop byte is accepted, the glitch output is low, the target reset is high and busy is low. No done strobe follows.
- R9: Reset-only holds the target reset low for RST_HOLD cycles, then releases it without a pulse and without a done strobe.
- R10: A sweep starts at the configured delay with width 1. Each attempt adds one to the width until the width limit is reached. The next attempt then uses width 1 and the delay plus one.
- R11: The sweep width limit is the configured width, or 1 when that is 0. The sweep ends after the attempt at the width limit whose delay has reached the sweep argument, and a start delay above the argument gives one row.
- R12: After reset the target reset output is high, and glitch, busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid_i | input | 1 | Command byte valid |
| rx_data_i | input | 8 | Command byte |
| tgt_rst_n_o | output | 1 | Active-low reset to the target board |
| glitch_sel_o | output | 1 | Power multiplexer select, high selects the glitch supply |
| busy_o | output | 1 | Attempt, sweep or reset sequence in progress |
| done_o | output | 1 | One-cycle end-of-attempt strobe |
| done_delay_o | output | 16 | Delay used by the finished attempt |
| done_width_o | output | 16 | Width used by the finished attempt |

## Verification
The bench aims at the off-by-one points of the timing chain:
- Zero delay must fire on the first cycle after release. A design that counted the delay one cycle short or long would move every glitch edge.
- Zero width must give a done strobe with no pulse. A careless down-counter would underflow and glitch for thousands of cycles.
- Commands sent while busy must not change the stored settings or start a second attempt.

Stop is sent in the middle of a pulse to catch a design that lets the pulse run out or still reports done. The sweeps check the nesting order and the boundaries, including a zero width limit and an end delay below the start. A swapped loop order, or a missing last row, shows up as a mismatch in the done values.

// File: rtl/glitch_pkg.sv
package glitch_pkg;

  localparam int ARG_W = 16;

  typedef enum logic [7:0] {
    OP_SET_DELAY = 8'h01,
    OP_SET_WIDTH = 8'h02,
    OP_RUN       = 8'h03,
    OP_TGT_RESET = 8'h04,
    OP_SWEEP     = 8'h05,
    OP_STOP      = 8'h06
  } opcode_e;

  typedef struct packed {
    opcode_e          op;
    logic [ARG_W-1:0] arg;
  } cmd_t;

  typedef enum logic [1:0] {
    PS_OP,
    PS_LO,
    PS_HI
  } parse_state_e;

  typedef enum logic [1:0] {
    AS_IDLE,
    AS_RESET,
    AS_DELAY,
    AS_PULSE
  } att_state_e;

endpackage

// File: rtl/glitch_cmd_rx.sv
module glitch_cmd_rx
  import glitch_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  output logic       cmd_vld_o,
  output cmd_t       cmd_o
);

  parse_state_e state_q, state_d;
  opcode_e      op_q, op_d;
  logic [7:0]   lo_q, lo_d;
  logic         vld_q, vld_d;
  cmd_t         cmd_q, cmd_d;

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    lo_d    = lo_q;
    vld_d   = 1'b0;
    cmd_d   = cmd_q;
    if (byte_vld_i) begin
      unique case (state_q)
        PS_OP: begin
          case (byte_i)
            OP_SET_DELAY, OP_SET_WIDTH, OP_SWEEP: begin
              op_d    = opcode_e'(byte_i);
              state_d = PS_LO;
            end
            OP_RUN, OP_TGT_RESET, OP_STOP: begin
              vld_d     = 1'b1;
              cmd_d.op  = opcode_e'(byte_i);
              cmd_d.arg = '0;
            end
            default: ;
          endcase
        end
        PS_LO: begin
          lo_d    = byte_i;
          state_d = PS_HI;
        end
        PS_HI: begin
          vld_d     = 1'b1;
          cmd_d.op  = op_q;
          cmd_d.arg = {byte_i, lo_q};
          state_d   = PS_OP;
        end
        default: state_d = PS_OP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_OP;
      op_q    <= OP_RUN;
      lo_q    <= '0;
      vld_q   <= 1'b0;
      cmd_q   <= '{op: OP_RUN, arg: '0};
    end else begin
      state_q <= state_d;
      vld_q   <= vld_d;
      if (byte_vld_i) begin
        op_q  <= op_d;
        lo_q  <= lo_d;
        cmd_q <= cmd_d;
      end
    end
  end

  assign cmd_vld_o = vld_q;
  assign cmd_o     = cmd_q;

  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld_o |-> (cmd_o.op inside {OP_SET_DELAY, OP_SET_WIDTH, OP_RUN,
                                    OP_TGT_RESET, OP_SWEEP, OP_STOP})); // R1

  AST_ARG_AFTER_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_o && (cmd_o.op inside {OP_SET_DELAY, OP_SET_WIDTH, OP_SWEEP}))
      |-> $past(state_q) == PS_HI); // R1

endmodule

// File: rtl/glitch_attempt.sv
module glitch_attempt
  import glitch_pkg::*;
#(
  parameter int RST_HOLD = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_i,
  input  logic             rst_only_i,
  input  logic [ARG_W-1:0] delay_i,
  input  logic [ARG_W-1:0] width_i,
  input  logic             abort_i,
  output logic             tgt_rst_n_o,
  output logic             glitch_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [ARG_W-1:0] done_delay_o,
  output logic [ARG_W-1:0] done_width_o
);

  localparam int HOLD_W = $clog2(RST_HOLD + 1);
  localparam int CNT_W  = (HOLD_W > ARG_W) ? HOLD_W : ARG_W;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_HOLD = CNT_W'(RST_HOLD - 1);

  att_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ARG_W-1:0] dly_q, dly_d;
  logic [ARG_W-1:0] wid_q, wid_d;
  logic             ronly_q, ronly_d;
  logic             done_q, done_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    dly_d   = dly_q;
    wid_d   = wid_q;
    ronly_d = ronly_q;
    done_d  = 1'b0;
    unique case (state_q)
      AS_IDLE: begin
        if (launch_i) begin
          state_d = AS_RESET;
          cnt_d   = CNT_HOLD;
          dly_d   = delay_i;
          wid_d   = width_i;
          ronly_d = rst_only_i;
        end
      end
      AS_RESET: begin
        if (cnt_zero) begin
          if (ronly_q) begin
            state_d = AS_IDLE;
          end else begin
            state_d = AS_DELAY;
            cnt_d   = CNT_W'(dly_q);
          end
        end else begin
          cnt_d = cnt_q - CNT_ONE;
        end
      end
      AS_DELAY: begin
        if (cnt_zero) begin
          if (wid_q == '0) begin
            state_d = AS_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = AS_PULSE;
            cnt_d   = CNT_W'(wid_q) - CNT_ONE;
          end
        end else begin
          cnt_d = cnt_q - CNT_ONE;
        end
      end
      AS_PULSE: begin
        if (cnt_zero) begin
          state_d = AS_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - CNT_ONE;
        end
      end
      default: state_d = AS_IDLE;
    endcase
    if (abort_i) begin
      state_d = AS_IDLE;
      done_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= AS_IDLE;
      cnt_q   <= '0;
      dly_q   <= '0;
      wid_q   <= '0;
      ronly_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      if (launch_i && (state_q == AS_IDLE)) begin
        dly_q   <= dly_d;
        wid_q   <= wid_d;
        ronly_q <= ronly_d;
      end
    end
  end

  assign tgt_rst_n_o  = (state_q != AS_RESET);
  assign glitch_o     = (state_q == AS_PULSE);
  assign busy_o       = (state_q != AS_IDLE);
  assign done_o       = done_q;
  assign done_delay_o = dly_q;
  assign done_width_o = wid_q;

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!glitch_o && tgt_rst_n_o && !done_o)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R5

  AST_NO_ZERO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(glitch_o) |-> (wid_q != '0)); // R4

  AST_PULSE_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(glitch_o) |-> ($past(state_q) == AS_DELAY)); // R3

  AST_PULSE_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(glitch_o) |-> (done_o || $past(abort_i))); // R5

  AST_HOLD_FROM_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tgt_rst_n_o) |-> $past(launch_i)); // R2

endmodule

// File: rtl/glitch_campaign.sv
module glitch_campaign
  import glitch_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_vld_i,
  input  cmd_t             cmd_i,
  input  logic             att_busy_i,
  input  logic             att_done_i,
  output logic             launch_o,
  output logic             rst_only_o,
  output logic [ARG_W-1:0] delay_o,
  output logic [ARG_W-1:0] width_o,
  output logic             abort_o,
  output logic             busy_o
);

  localparam logic [ARG_W-1:0] ARG_ONE = ARG_W'(1);

  logic [ARG_W-1:0] dcfg_q, dcfg_d;
  logic [ARG_W-1:0] wcfg_q, wcfg_d;
  logic [ARG_W-1:0] cur_d_q, cur_d_d;
  logic [ARG_W-1:0] cur_w_q, cur_w_d;
  logic [ARG_W-1:0] end_d_q, end_d_d;
  logic [ARG_W-1:0] wmax_q, wmax_d;
  logic             sweep_q, sweep_d;
  logic             launch_q, launch_d;
  logic             ronly_q, ronly_d;
  logic             busy_all;
  logic             accept;
  logic             stop_cmd;

  assign busy_all = att_busy_i | sweep_q | launch_q;
  assign stop_cmd = cmd_vld_i && (cmd_i.op == OP_STOP);
  assign accept   = cmd_vld_i && !busy_all;

  always_comb begin
    dcfg_d   = dcfg_q;
    wcfg_d   = wcfg_q;
    cur_d_d  = cur_d_q;
    cur_w_d  = cur_w_q;
    end_d_d  = end_d_q;
    wmax_d   = wmax_q;
    sweep_d  = sweep_q;
    ronly_d  = ronly_q;
    launch_d = 1'b0;
    if (stop_cmd) begin
      sweep_d = 1'b0;
    end else if (accept) begin
      unique case (cmd_i.op)
        OP_SET_DELAY: dcfg_d = cmd_i.arg;
        OP_SET_WIDTH: wcfg_d = cmd_i.arg;
        OP_RUN: begin
          cur_d_d  = dcfg_q;
          cur_w_d  = wcfg_q;
          ronly_d  = 1'b0;
          launch_d = 1'b1;
        end
        OP_TGT_RESET: begin
          ronly_d  = 1'b1;
          launch_d = 1'b1;
        end
        OP_SWEEP: begin
          cur_d_d  = dcfg_q;
          cur_w_d  = ARG_ONE;
          end_d_d  = cmd_i.arg;
          wmax_d   = (wcfg_q == '0) ? ARG_ONE : wcfg_q;
          sweep_d  = 1'b1;
          ronly_d  = 1'b0;
          launch_d = 1'b1;
        end
        default: ;
      endcase
    end else if (att_done_i && sweep_q) begin
      if (cur_w_q < wmax_q) begin
        cur_w_d  = cur_w_q + ARG_ONE;
        launch_d = 1'b1;
      end else if (cur_d_q < end_d_q) begin
        cur_d_d  = cur_d_q + ARG_ONE;
        cur_w_d  = ARG_ONE;
        launch_d = 1'b1;
      end else begin
        sweep_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcfg_q   <= '0;
      wcfg_q   <= '0;
      cur_d_q  <= '0;
      cur_w_q  <= '0;
      end_d_q  <= '0;
      wmax_q   <= ARG_ONE;
      sweep_q  <= 1'b0;
      launch_q <= 1'b0;
      ronly_q  <= 1'b0;
    end else begin
      sweep_q  <= sweep_d;
      launch_q <= launch_d;
      if (accept || (att_done_i && sweep_q)) begin
        dcfg_q  <= dcfg_d;
        wcfg_q  <= wcfg_d;
        cur_d_q <= cur_d_d;
        cur_w_q <= cur_w_d;
        end_d_q <= end_d_d;
        wmax_q  <= wmax_d;
        ronly_q <= ronly_d;
      end
    end
  end

  assign launch_o   = launch_q;
  assign rst_only_o = ronly_q;
  assign delay_o    = cur_d_q;
  assign width_o    = cur_w_q;
  assign abort_o    = stop_cmd;
  assign busy_o     = busy_all;

  AST_SWEEP_WIDTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_q |-> ((cur_w_q >= ARG_ONE) && (cur_w_q <= wmax_q))); // R11

  AST_LAUNCH_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    launch_o |-> !att_busy_i); // R6

  AST_BUSY_KEEPS_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_i && busy_all) |=> ($stable(dcfg_q) && $stable(wcfg_q))); // R7

  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_i && att_busy_i && !att_done_i) |=> !launch_o); // R7

endmodule

// File: rtl/glitch_timing_ctrl.sv
module glitch_timing_ctrl
  import glitch_pkg::*;
#(
  parameter int RST_HOLD = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  output logic        tgt_rst_n_o,
  output logic        glitch_sel_o,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] done_delay_o,
  output logic [15:0] done_width_o
);

  logic             cmd_vld;
  cmd_t             cmd;
  logic             launch;
  logic             rst_only;
  logic [ARG_W-1:0] run_delay;
  logic [ARG_W-1:0] run_width;
  logic             abort;
  logic             att_busy;
  logic             att_done;

  glitch_cmd_rx u_cmd_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_vld_i (rx_valid_i),
    .byte_i     (rx_data_i),
    .cmd_vld_o  (cmd_vld),
    .cmd_o      (cmd)
  );

  glitch_campaign u_campaign (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_vld_i  (cmd_vld),
    .cmd_i      (cmd),
    .att_busy_i (att_busy),
    .att_done_i (att_done),
    .launch_o   (launch),
    .rst_only_o (rst_only),
    .delay_o    (run_delay),
    .width_o    (run_width),
    .abort_o    (abort),
    .busy_o     (busy_o)
  );

  glitch_attempt #(
    .RST_HOLD (RST_HOLD)
  ) u_attempt (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch_i     (launch),
    .rst_only_i   (rst_only),
    .delay_i      (run_delay),
    .width_i      (run_width),
    .abort_i      (abort),
    .tgt_rst_n_o  (tgt_rst_n_o),
    .glitch_o     (glitch_sel_o),
    .busy_o       (att_busy),
    .done_o       (att_done),
    .done_delay_o (done_delay_o),
    .done_width_o (done_width_o)
  );

  assign done_o = att_done;

  AST_GLITCH_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (glitch_sel_o || !tgt_rst_n_o) |-> busy_o); // R6

endmodule

// File: tb/glitch_timing_ctrl_tb_top.sv
module glitch_timing_ctrl_tb_top;

  localparam int HOLD = 16;

  logic        clk;
  logic        rst_n;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        tgt_rst_n;
  logic        glitch;
  logic        busy;
  logic        done;
  logic [15:0] done_delay;
  logic [15:0] done_width;

  glitch_timing_ctrl #(.RST_HOLD(HOLD)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid_i   (rx_valid),
    .rx_data_i    (rx_data),
    .tgt_rst_n_o  (tgt_rst_n),
    .glitch_sel_o (glitch),
    .busy_o       (busy),
    .done_o       (done),
    .done_delay_o (done_delay),
    .done_width_o (done_width)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    int d;
    int w;
    bit single;
  } exp_t;

  exp_t exp_q[$];
  int n_chk  = 0;
  int n_fail = 0;
  int n_done = 0;
  int glitch_total = 0;
  int last_hold = 0;
  bit finished = 0;

  function automatic void chk(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endfunction

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Monitor: measures each attempt from reset release and scores it at done.
  bit in_hold = 0;
  bit tracking = 0;
  bit busy_bad = 0;
  int hold_cnt = 0;
  int idx = 0;
  int first_hi = -1;
  int hi_cnt = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      in_hold  = 0;
      tracking = 0;
    end else begin
      if (!tgt_rst_n) begin
        if (!in_hold) begin
          in_hold  = 1;
          hold_cnt = 0;
          busy_bad = 0;
        end
        hold_cnt++;
        tracking = 0;
        if (!busy) busy_bad = 1;
      end else if (in_hold) begin
        in_hold   = 0;
        tracking  = 1;
        idx       = 0;
        first_hi  = -1;
        hi_cnt    = 0;
        last_hold = hold_cnt;
      end else if (tracking) begin
        idx++;
      end
      if (glitch) begin
        glitch_total++;
        if (tracking) begin
          if (first_hi < 0) first_hi = idx;
          hi_cnt++;
          if (!busy) busy_bad = 1;
        end
      end
      if (done) begin
        n_done++;
        if (exp_q.size() == 0) begin
          chk(0, "R5 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(last_hold == HOLD, "R2 reset hold", last_hold, HOLD);
          chk(first_hi == ((e.w > 0) ? e.d + 1 : -1), "R3 glitch start", first_hi,
              (e.w > 0) ? e.d + 1 : -1);
          chk(hi_cnt == e.w, "R4 glitch width", hi_cnt, e.w);
          chk(idx == e.d + 1 + e.w, "R5 done cycle", idx, e.d + 1 + e.w);
          chk(int'(done_delay) == e.d, "R5 done delay", int'(done_delay), e.d);
          chk(int'(done_width) == e.w, "R5 done width", int'(done_width), e.w);
          chk(!busy_bad, "R6 busy during attempt", busy_bad, 0);
          if (e.single) chk(!busy, "R6 busy low at done", busy, 0);
        end
        tracking = 0;
      end
    end
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_arg(input logic [7:0] op, input int val);
    send_byte(op);
    send_byte(val[7:0]);
    send_byte(val[15:8]);
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_push(input int d, input int w);
    exp_t e;
    e.d = d; e.w = w; e.single = 1;
    exp_q.push_back(e);
    send_byte(8'h03);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    rx_valid = 1'b0;
    rx_data  = 8'h00;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(tgt_rst_n == 1'b1, "R12 target reset high", tgt_rst_n, 1);
    chk(glitch == 1'b0, "R12 glitch low", glitch, 0);
    chk(busy == 1'b0, "R12 busy low", busy, 0);
    chk(done == 1'b0, "R12 done low", done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: an unknown opcode must not eat the following bytes
    send_byte(8'h7F);
    send_arg(8'h01, 5);
    send_arg(8'h02, 3);
    run_push(5, 3);
    wait_idle();

    // R3: zero delay
    send_arg(8'h01, 0);
    send_arg(8'h02, 4);
    run_push(0, 4);
    wait_idle();

    // R4: zero width, no pulse
    send_arg(8'h01, 2);
    send_arg(8'h02, 0);
    run_push(2, 0);
    wait_idle();

    // R7: settings and starts while busy are dropped
    send_arg(8'h01, 20);
    send_arg(8'h02, 2);
    run_push(20, 2);
    while (tgt_rst_n) @(negedge clk);
    chk(busy == 1'b1, "R6 busy in reset hold", busy, 1);
    send_arg(8'h01, 1);
    send_byte(8'h03);
    wait_idle();
    chk(exp_q.size() == 0, "R7 no extra attempt", exp_q.size(), 0);
    run_push(20, 2);
    wait_idle();

    // R8: stop in the middle of a pulse
    begin
      int done_before;
      send_arg(8'h01, 3);
      send_arg(8'h02, 50);
      send_byte(8'h03);
      while (!glitch) @(negedge clk);
      repeat (5) @(negedge clk);
      done_before = n_done;
      send_byte(8'h06);
      @(negedge clk);
      chk(glitch == 1'b0, "R8 glitch dropped", glitch, 0);
      chk(tgt_rst_n == 1'b1, "R8 reset released", tgt_rst_n, 1);
      chk(busy == 1'b0, "R8 busy cleared", busy, 0);
      repeat (80) @(negedge clk);
      chk(n_done == done_before, "R8 no done after stop", n_done, done_before);
    end

    // R9: reset only
    begin
      int done_before;
      int glitch_before;
      done_before   = n_done;
      glitch_before = glitch_total;
      send_byte(8'h04);
      wait_idle();
      chk(last_hold == HOLD, "R9 reset-only hold", last_hold, HOLD);
      chk(n_done == done_before, "R9 no done", n_done, done_before);
      chk(glitch_total == glitch_before, "R9 no pulse", glitch_total, glitch_before);
    end

    // R10: sweep order, width inner loop, delay outer loop
    begin
      exp_t e;
      send_arg(8'h01, 3);
      send_arg(8'h02, 2);
      e.single = 0;
      e.d = 3; e.w = 1; exp_q.push_back(e);
      e.d = 3; e.w = 2; exp_q.push_back(e);
      e.d = 4; e.w = 1; exp_q.push_back(e);
      e.d = 4; e.w = 2; exp_q.push_back(e);
      send_arg(8'h05, 4);
      wait_idle();
      chk(exp_q.size() == 0, "R10 all sweep points", exp_q.size(), 0);
      chk(busy == 1'b0, "R11 sweep finished", busy, 0);
    end

    // R11: zero width limit becomes 1, end delay below start gives one row
    begin
      exp_t e;
      send_arg(8'h01, 7);
      send_arg(8'h02, 0);
      e.single = 0;
      e.d = 7; e.w = 1; exp_q.push_back(e);
      send_arg(8'h05, 6);
      wait_idle();
      chk(exp_q.size() == 0, "R11 single sweep point", exp_q.size(), 0);
      chk(busy == 1'b0, "R11 sweep ended", busy, 0);
    end

    repeat (10) @(negedge clk);
    report();
  end

endmodule